// File: doc/BRIEF.md
# Quad Bus Transceiver with Parity

The block is one slice of a bidirectional data bus interface, four bits wide by default. On the send side a word from the local side is captured into a driver register on the rising edge of a driver clock. While the active-low bus enable is low, the inverse of that register goes out on the bus. On the receive side the bus value passes through a latch that is transparent while its active-low enable is low and holds while the enable is high. The latch feeds the receiver outputs, which carry the inverse of the latched bus value and have their own active-low output enable.

A single parity output is shared by both directions. While the block is sending, it gives the parity of the local input word. While it is receiving, it gives the parity of the latched bus word. The bidirectional bus appears as separate `bus_in`, `bus_out` and `bus_oe` signals. The three-state receiver outputs appear as `rx_data` and `rx_oe`.

All state lives in the system clock domain. The driver clock and the latch enable are sampled by `clk`. A synchronous active-high reset clears the driver register and the receive latch to zero.

Top module: `quad_bus_xcvr`

## Requirements
- R1: The driver register loads `a_in` in the `clk` cycle after `drv_clk` is sampled high following a low sample. At no other time does it change, except on reset. Holding `drv_clk` high loads only once.
- R2: `bus_oe` is 1 exactly when `bus_en_n` is 0. With `bus_en_n` at 1 the bus is released and acts as an input.
- R3: `bus_out` is the bitwise inverse of the driver register. Loading 0000 gives 1111, 0001 gives 1110 and 1111 gives 0000.
- R4: While `le_n` is 0 the receive latch is transparent, and `rx_data` follows the inverse of `bus_in` in the same cycle. While `le_n` is 1 the latch holds the value it had on the last `clk` edge with `le_n` at 0, and bus changes have no effect on `rx_data` or `parity`.
- R5: `rx_data` is the inverse of the latched bus value (bus 0001 gives 1110). `rx_oe` is 1 exactly when `oe_n` is 0, and 0 (outputs released) when `oe_n` is 1.
- R6: While `bus_en_n` is 0, `parity` is the XOR of the bits of `a_in`, which is 1 for an odd count of ones. The values are 0000→0, 0001→1, 0011→0, 0111→1 and 1111→0. It follows `a_in` without waiting for a driver clock edge.
- R7: While `bus_en_n` is 1, `parity` is the XOR of the bits of the latched bus word (bus 0001→1, 0011→0), so it follows the latch's transparent and hold behaviour.
- R8: A `clk` edge with `rst` at 1 clears the driver register and the latch to 0. After reset, with `le_n` at 1, `bus_out` is 1111 and `rx_data` is 1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | Local data word to send |
| drv_clk | input | 1 | Driver clock; its rising edge loads the driver register |
| bus_en_n | input | 1 | Active-low bus drive enable, which also selects the parity source |
| bus_in | input | WIDTH | Value seen on the bus |
| bus_out | output | WIDTH | Value driven onto the bus (inverse of the driver register) |
| bus_oe | output | 1 | Bus drive enable |
| le_n | input | 1 | Active-low receive latch enable (0 = transparent) |
| oe_n | input | 1 | Active-low receiver output enable |
| rx_data | output | WIDTH | Receiver output data (inverse of the latched bus) |
| rx_oe | output | 1 | Receiver output enable |
| parity | output | 1 | Odd-count parity of sent or received data |

## Verification
The bench holds `drv_clk` high for several system clocks to show that a design loading on level instead of edge would keep following `a_in`. It then closes the latch and changes the bus, including moving from 1111 to 0000. A latch that stayed transparent would change `rx_data` and the receive-side parity there. Parity is checked in both directions with the same words, so a design that left the parity source fixed, or reported the inverted received value as a different parity, is caught. Reset is applied in the middle of operation to catch a design that clears only one of its two stores, or clears the driver register to the bus value instead of to zero.

// File: rtl/qbx_pkg.sv
package qbx_pkg;
  typedef enum logic {
    DIR_SEND    = 1'b0,
    DIR_RECEIVE = 1'b1
  } dir_e;
endpackage

// File: rtl/qbx_drv_stage.sv
module qbx_drv_stage #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             drv_clk,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] word_q
);
  logic drv_clk_q;
  logic load;

  assign load = drv_clk && !drv_clk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_clk_q <= 1'b1;
      word_q    <= '0;
    end else begin
      drv_clk_q <= drv_clk;
      if (load) word_q <= a_in;
    end
  end
endmodule

// File: rtl/qbx_rx_latch.sv
module qbx_rx_latch #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             le_n,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] seen
);
  logic [WIDTH-1:0] held_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)        held_q[b] <= 1'b0;
      else if (!le_n) held_q[b] <= bus_in[b];
    end
    assign seen[b] = le_n ? held_q[b] : bus_in[b];
  end
endmodule

// File: rtl/qbx_parity_sel.sv
module qbx_parity_sel
  import qbx_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  dir_e             dir,
  input  logic [WIDTH-1:0] send_word,
  input  logic [WIDTH-1:0] recv_word,
  output logic             parity
);
  logic send_par;
  logic recv_par;

  assign send_par = ^send_word;
  assign recv_par = ^recv_word;

  always_comb begin
    case (dir)
      DIR_SEND: parity = send_par;
      default:  parity = recv_par;
    endcase
  end
endmodule

// File: rtl/quad_bus_xcvr.sv
module quad_bus_xcvr
  import qbx_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic             drv_clk,
  input  logic             bus_en_n,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe,
  input  logic             le_n,
  input  logic             oe_n,
  output logic [WIDTH-1:0] rx_data,
  output logic             rx_oe,
  output logic             parity
);
  logic [WIDTH-1:0] drv_word;
  logic [WIDTH-1:0] latched;
  dir_e             dir;

  assign dir = bus_en_n ? DIR_RECEIVE : DIR_SEND;

  qbx_drv_stage #(.WIDTH(WIDTH)) drv_i (
    .clk    (clk),
    .rst    (rst),
    .drv_clk(drv_clk),
    .a_in   (a_in),
    .word_q (drv_word)
  );

  qbx_rx_latch #(.WIDTH(WIDTH)) lat_i (
    .clk   (clk),
    .rst   (rst),
    .le_n  (le_n),
    .bus_in(bus_in),
    .seen  (latched)
  );

  qbx_parity_sel #(.WIDTH(WIDTH)) par_i (
    .dir      (dir),
    .send_word(a_in),
    .recv_word(latched),
    .parity   (parity)
  );

  assign bus_out = ~drv_word;
  assign bus_oe  = (dir == DIR_SEND);
  assign rx_data = ~latched;
  assign rx_oe   = !oe_n;
endmodule

// File: rtl/qbx_checker.sv
module qbx_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_in,
  input logic             drv_clk,
  input logic             bus_en_n,
  input logic [WIDTH-1:0] bus_in,
  input logic [WIDTH-1:0] bus_out,
  input logic             bus_oe,
  input logic             le_n,
  input logic             oe_n,
  input logic [WIDTH-1:0] rx_data,
  input logic             rx_oe,
  input logic             parity
);
  // R1: no driver clock rising edge means the bus word is unchanged
  a_r1_drv_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !(drv_clk && !$past(drv_clk))) |=> $stable(bus_out));

  // R3: a rising edge loads the inverse of a_in onto the bus
  a_r3_drv_load: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && drv_clk && !$past(drv_clk)) |=> (bus_out == ~$past(a_in)));

  // R2
  a_r2_bus_release: assert property (@(posedge clk) disable iff (rst)
    bus_oe == !bus_en_n);

  // R4: transparent while enable low
  a_r4_transparent: assert property (@(posedge clk) disable iff (rst)
    !le_n |-> (rx_data == ~bus_in));

  // R4: holds while enable stays high
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (le_n && $past(le_n) && !$past(rst)) |-> $stable(rx_data));

  // R5
  a_r5_rx_enable: assert property (@(posedge clk) disable iff (rst)
    rx_oe == !oe_n);

  // R6
  a_r6_send_parity: assert property (@(posedge clk) disable iff (rst)
    !bus_en_n |-> (parity == ^a_in));

  // R7
  a_r7_recv_parity: assert property (@(posedge clk) disable iff (rst)
    bus_en_n |-> (parity == ^(~rx_data)));

  // R8
  a_r8_reset_clear: assert property (@(posedge clk)
    (rst && !le_n) |=> (bus_out == '1));
endmodule

bind quad_bus_xcvr qbx_checker #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .a_in(a_in), .drv_clk(drv_clk), .bus_en_n(bus_en_n),
  .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .le_n(le_n),
  .oe_n(oe_n), .rx_data(rx_data), .rx_oe(rx_oe), .parity(parity)
);

// File: tb/quad_bus_xcvr_tb_top.sv
module quad_bus_xcvr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int NVEC = 10;
  // {receive, stimulus[4], expected word[4], expected parity}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 4'b0000, 4'b1111, 1'b0},
    {1'b0, 4'b0001, 4'b1110, 1'b1},
    {1'b0, 4'b0011, 4'b1100, 1'b0},
    {1'b0, 4'b0111, 4'b1000, 1'b1},
    {1'b0, 4'b1111, 4'b0000, 1'b0},
    {1'b1, 4'b0000, 4'b1111, 1'b0},
    {1'b1, 4'b0001, 4'b1110, 1'b1},
    {1'b1, 4'b0011, 4'b1100, 1'b0},
    {1'b1, 4'b0111, 4'b1000, 1'b1},
    {1'b1, 4'b1111, 4'b0000, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0;
  logic drv_clk = 1'b0;
  logic bus_en_n = 1'b1;
  logic [W-1:0] bus_in = '0;
  logic le_n = 1'b1;
  logic oe_n = 1'b1;
  logic [W-1:0] bus_out, rx_data;
  logic bus_oe, rx_oe, parity;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_bus_xcvr #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .drv_clk(drv_clk), .bus_en_n(bus_en_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .le_n(le_n),
    .oe_n(oe_n), .rx_data(rx_data), .rx_oe(rx_oe), .parity(parity)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic drv_pulse(input logic [W-1:0] d);
    a_in = d;
    drv_clk = 1'b1;
    step();
    drv_clk = 1'b0;
    step();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    check("R8 reset bus_out", bus_out, 4'b1111);
    check("R8 reset rx_data", rx_data, 4'b1111);
    check("R5 rx_oe released", {3'b0, rx_oe}, 4'b0000);
    check("R2 bus released", {3'b0, bus_oe}, 4'b0000);

    for (int i = 0; i < NVEC; i++) begin
      if (!VEC[i][9]) begin
        bus_en_n = 1'b0;
        a_in = VEC[i][8:5];
        #1;
        check("R6 send parity", {3'b0, parity}, {3'b0, VEC[i][0]});
        check("R2 bus driven", {3'b0, bus_oe}, 4'b0001);
        drv_pulse(VEC[i][8:5]);
        check("R3 bus_out", bus_out, VEC[i][4:1]);
      end else begin
        bus_en_n = 1'b1;
        le_n = 1'b0;
        oe_n = 1'b0;
        bus_in = VEC[i][8:5];
        step();
        check("R4 transparent rx_data", rx_data, VEC[i][4:1]);
        check("R7 receive parity", {3'b0, parity}, {3'b0, VEC[i][0]});
        check("R5 rx_oe driven", {3'b0, rx_oe}, 4'b0001);
      end
    end

    // R4: latch holds 1111 bus value; later 0000 and 0001 ignored
    bus_in = 4'b1111;
    step();
    le_n = 1'b1;
    step();
    bus_in = 4'b0000;
    step();
    check("R4 hold after bus 0000", rx_data, 4'b0000);
    bus_in = 4'b0001;
    step();
    check("R4 hold after bus 0001", rx_data, 4'b0000);
    check("R7 parity held", {3'b0, parity}, 4'b0000);
    oe_n = 1'b1;
    #1;
    check("R5 rx_oe off", {3'b0, rx_oe}, 4'b0000);

    // R1: level-held driver clock loads once
    bus_en_n = 1'b0;
    a_in = 4'b0101;
    drv_clk = 1'b1;
    step();
    check("R1 load on rise", bus_out, 4'b1010);
    a_in = 4'b0011;
    repeat (3) step();
    check("R1 no load while high", bus_out, 4'b1010);
    drv_clk = 1'b0;
    a_in = 4'b1110;
    repeat (2) step();
    check("R1 no load while low", bus_out, 4'b1010);
    check("R6 parity follows a_in before edge", {3'b0, parity}, 4'b0001);
    drv_pulse(4'b1000);
    check("R3 reload", bus_out, 4'b0111);

    // R8: mid-run reset clears both stores
    le_n = 1'b0;
    bus_in = 4'b0110;
    step();
    le_n = 1'b1;
    step();
    check("R4 latched 0110", rx_data, 4'b1001);
    rst = 1'b1;
    step();
    rst = 1'b0;
    step();
    check("R8 mid reset bus_out", bus_out, 4'b1111);
    check("R8 mid reset rx_data", rx_data, 4'b1111);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule